// File: doc/BRIEF.md
# Serial Port Interrupt Prioritizer

This block turns the status events of an asynchronous serial port into a single prioritized interrupt request. It watches five conditions: a received character with an error, a clean received character, an empty transmit holding register, an idle receive line and a baud counter reaching zero. A 24-bit control register holds one enable bit for each source. The block presents one request line together with the index of the most urgent pending source.

Each source is cleared in its own way. The two receive sources and the transmit source are level sources. Each follows its status flag and is withdrawn by a bus access: a receive data read, a transmit data write, or a status read followed by a receive data read. The idle and timer sources come from short events. They are held in sticky latches until the CPU acknowledges that index. Idle detection counts bit-time ticks while the line stays high. Its threshold is 10 or 11 ticks, chosen by the frame length input, and it fires once for each high stretch.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After reset, irq_o is 0, irq_idx_o is 0 and every control bit is 0, so no source can request.
- R2: Source indices are fixed: 0 = receive error, 1 = receive, 2 = transmit, 3 = idle, 4 = timer. When several sources request, irq_idx_o shows the lowest index.
- R3: The receive error source (enable bit 16) requests while rx_full_i is high and at least one of par_err_i, frm_err_i or ovr_err_i is high. A receive data read alone does not clear it. It is cleared only by a receive data read that follows a status read.
- R4: The receive source (enable bit 11) requests while rx_full_i is high, and a receive data read clears it. It is held back while the receive error source requests. A fresh rx_full_i rising edge re-arms it.
- R5: The transmit source (enable bit 12) requests while tx_empty_i is high, and a transmit data write clears it. It re-arms when tx_empty_i falls and rises again.
- R6: The idle source (enable bit 10) latches at the 10th consecutive bit_tick_i with rxd_i high when frame11_i is 0, and at the 11th when frame11_i is 1. It fires once per high stretch; a tick with rxd_i low restarts the count.
- R7: The timer source (enable bit 13) latches on a baud_zero_i pulse.
- R8: A disabled source never requests. A pulse event that occurs while its enable is clear is not latched.
- R9: The idle and timer latches are cleared only by ack_i with ack_idx_i equal to their own index. An acknowledge for another index leaves them pending.
- R10: irq_idx_o is 0 whenever irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 24 | Control register write data |
| rx_full_i | input | 1 | Receive data register full |
| par_err_i | input | 1 | Parity error flag |
| frm_err_i | input | 1 | Framing error flag |
| ovr_err_i | input | 1 | Overrun error flag |
| tx_empty_i | input | 1 | Transmit data register empty |
| rxd_i | input | 1 | Receive line level |
| bit_tick_i | input | 1 | One pulse per bit time |
| frame11_i | input | 1 | 1 = 11-bit frames, 0 = 10-bit frames |
| baud_zero_i | input | 1 | Baud counter reached zero |
| stat_rd_i | input | 1 | Status register read strobe |
| rx_rd_i | input | 1 | Receive data read strobe |
| tx_wr_i | input | 1 | Transmit data write strobe |
| ack_i | input | 1 | Interrupt accepted |
| ack_idx_i | input | 3 | Index of the accepted source |
| irq_o | output | 1 | Interrupt request |
| irq_idx_o | output | 3 | Index of the highest-priority request |

## Verification
The hardest situation to reach is a stack of all five sources pending at once, so that each clear exposes the next index in order. Reaching it means latching the idle source with a full run of high ticks, pulsing the timer and raising the level flags. The stack is then unwound by an acknowledge or a bus access at each level. The error clear needs a separate sequence: a receive read alone must leave the request in place, and only a status read followed by a receive read may remove it. Idle detection is driven with runs one tick short of each threshold and continued past it. This shows both the exact firing point and that a stretch fires only once.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NSRC    = 5;
  // source index doubles as priority (0 highest)
  localparam int I_ERR   = 0;
  localparam int I_RX    = 1;
  localparam int I_TX    = 2;
  localparam int I_IDLE  = 3;
  localparam int I_TMR   = 4;
  // control register enable positions
  localparam int EN_ERR  = 16;
  localparam int EN_RX   = 11;
  localparam int EN_TX   = 12;
  localparam int EN_IDLE = 10;
  localparam int EN_TMR  = 13;
endpackage

// File: rtl/sio_lvl_src.sv
module sio_lvl_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cond_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic req_o
);
  logic served_q;

  // served until the flag drops, so a slow flag cannot re-raise the request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      served_q <= 1'b0;
    else if (!cond_i) served_q <= 1'b0;
    else if (clr_i)   served_q <= 1'b1;
  end

  assign req_o = en_i & cond_i & ~served_q & ~mask_i;
endmodule

// File: rtl/sio_pulse_src.sv
module sio_pulse_src #(
  parameter int IDX_W  = 3,
  parameter int SRC_ID = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             set_i,
  input  logic             ack_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  output logic             req_o
);
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(SRC_ID);

  logic pend_q;
  logic ack_hit;

  assign ack_hit = ack_i & (ack_idx_i == MY_IDX);

  // new event wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pend_q <= 1'b0;
    else if (set_i && en_i)   pend_q <= 1'b1;
    else if (ack_hit)         pend_q <= 1'b0;
  end

  assign req_o = pend_q & en_i;
endmodule

// File: rtl/sio_idle_det.sv
module sio_idle_det #(
  parameter int CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  input  logic long_i,
  output logic hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [CNT_W-1:0] thr;

  assign thr   = long_i ? CNT_W'(11) : CNT_W'(10);
  assign hit_o = tick_i & line_i & ~done_q & ((cnt_q + CNT_W'(1)) == thr);

  // count stops once the stretch has fired; a low tick restarts it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick_i) begin
      if (!line_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (!done_q) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (hit_o) done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int CTRL_W = 24,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              rx_full_i,
  input  logic              par_err_i,
  input  logic              frm_err_i,
  input  logic              ovr_err_i,
  input  logic              tx_empty_i,
  input  logic              rxd_i,
  input  logic              bit_tick_i,
  input  logic              frame11_i,
  input  logic              baud_zero_i,
  input  logic              stat_rd_i,
  input  logic              rx_rd_i,
  input  logic              tx_wr_i,
  input  logic              ack_i,
  input  logic [IDX_W-1:0]  ack_idx_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  irq_idx_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              arm_q;
  logic              err_cond;
  logic              idle_hit;
  logic [NSRC-1:0]   req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
  end

  // status read arms the error clear; the next data read consumes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        arm_q <= 1'b0;
    else if (rx_rd_i)   arm_q <= 1'b0;
    else if (stat_rd_i) arm_q <= 1'b1;
  end

  assign err_cond = rx_full_i & (par_err_i | frm_err_i | ovr_err_i);

  sio_lvl_src u_err (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .en_i  (ctrl_q[EN_ERR]),
    .cond_i(err_cond),
    .mask_i(1'b0),
    .clr_i (arm_q & rx_rd_i),
    .req_o (req[I_ERR])
  );

  sio_lvl_src u_rx (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .en_i  (ctrl_q[EN_RX]),
    .cond_i(rx_full_i),
    .mask_i(req[I_ERR]),
    .clr_i (rx_rd_i),
    .req_o (req[I_RX])
  );

  sio_lvl_src u_tx (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .en_i  (ctrl_q[EN_TX]),
    .cond_i(tx_empty_i),
    .mask_i(1'b0),
    .clr_i (tx_wr_i),
    .req_o (req[I_TX])
  );

  sio_idle_det #(.CNT_W(CNT_W)) u_idle_det (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .tick_i(bit_tick_i),
    .line_i(rxd_i),
    .long_i(frame11_i),
    .hit_o (idle_hit)
  );

  sio_pulse_src #(.IDX_W(IDX_W), .SRC_ID(I_IDLE)) u_idle (
    .clk_i    (clk_i), .rst_ni (rst_ni),
    .en_i     (ctrl_q[EN_IDLE]),
    .set_i    (idle_hit),
    .ack_i    (ack_i),
    .ack_idx_i(ack_idx_i),
    .req_o    (req[I_IDLE])
  );

  sio_pulse_src #(.IDX_W(IDX_W), .SRC_ID(I_TMR)) u_tmr (
    .clk_i    (clk_i), .rst_ni (rst_ni),
    .en_i     (ctrl_q[EN_TMR]),
    .set_i    (baud_zero_i),
    .ack_i    (ack_i),
    .ack_idx_i(ack_idx_i),
    .req_o    (req[I_TMR])
  );

  sio_irq_prio #(.N(NSRC), .IDX_W(IDX_W)) u_prio (
    .req_i(req),
    .any_o(irq_o),
    .idx_o(irq_idx_o)
  );
endmodule

// File: rtl/sio_irq_ctrl_chk.sv
module sio_irq_ctrl_chk
  import sio_irq_pkg::*;
#(
  parameter int CTRL_W = 24,
  parameter int IDX_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_full_i,
  input logic              par_err_i,
  input logic              frm_err_i,
  input logic              ovr_err_i,
  input logic              tx_empty_i,
  input logic              bit_tick_i,
  input logic              baud_zero_i,
  input logic              rx_rd_i,
  input logic              tx_wr_i,
  input logic              ack_i,
  input logic [IDX_W-1:0]  ack_idx_i,
  input logic              irq_o,
  input logic [IDX_W-1:0]  irq_idx_o,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              arm_q
);
  logic any_err;
  assign any_err = par_err_i | frm_err_i | ovr_err_i;

  p_idx_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> irq_idx_o == '0);

  p_err_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_idx_o == IDX_W'(I_ERR)) |-> (ctrl_q[EN_ERR] && rx_full_i && any_err));

  p_err_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && arm_q && rx_full_i && any_err) |=> !(irq_o && irq_idx_o == IDX_W'(I_ERR)));

  p_rx_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && rx_full_i) |=> !(irq_o && irq_idx_o == IDX_W'(I_RX)));

  p_tx_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && tx_empty_i) |=> !(irq_o && irq_idx_o == IDX_W'(I_TX)));

  p_idle_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_idx_i == IDX_W'(I_IDLE) && !bit_tick_i)
      |=> !(irq_o && irq_idx_o == IDX_W'(I_IDLE)));

  p_tmr_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_idx_i == IDX_W'(I_TMR) && !baud_zero_i)
      |=> !(irq_o && irq_idx_o == IDX_W'(I_TMR)));

  p_tmr_enable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_idx_o == IDX_W'(I_TMR)) |-> ctrl_q[EN_TMR]);
endmodule

bind sio_irq_ctrl sio_irq_ctrl_chk #(.CTRL_W(CTRL_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sio_irq_ctrl_test.sv
module sio_irq_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [23:0] ctrl_wdata_i = '0;
  logic        rx_full_i = 1'b0, par_err_i = 1'b0, frm_err_i = 1'b0, ovr_err_i = 1'b0;
  logic        tx_empty_i = 1'b0, rxd_i = 1'b0, bit_tick_i = 1'b0, frame11_i = 1'b0;
  logic        baud_zero_i = 1'b0, stat_rd_i = 1'b0, rx_rd_i = 1'b0, tx_wr_i = 1'b0;
  logic        ack_i = 1'b0;
  logic [2:0]  ack_idx_i = '0;
  logic        irq_o;
  logic [2:0]  irq_idx_o;

  int checks = 0;
  int errors = 0;

  localparam logic [23:0] ALL_EN = 24'h013C00; // bits 16,13,12,11,10

  always #4 clk_i = ~clk_i;

  sio_irq_ctrl uut (.*);

  task automatic check(input logic ei, input logic [2:0] ex, input string tag);
    #1;
    checks++;
    if (irq_o !== ei || (ei && irq_idx_o !== ex) || (!ei && irq_idx_o !== 3'd0)) begin
      errors++;
      $display("FAIL %s: irq=%0b idx=%0d expected irq=%0b idx=%0d", tag, irq_o, irq_idx_o, ei,
               ei ? ex : 3'd0);
    end
  endtask

  task automatic set_ctrl(input logic [23:0] v);
    @(negedge clk_i); ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk_i); ctrl_we_i = 1'b0;
  endtask

  task automatic stat_rd();
    @(negedge clk_i); stat_rd_i = 1'b1; @(negedge clk_i); stat_rd_i = 1'b0;
  endtask
  task automatic rx_rd();
    @(negedge clk_i); rx_rd_i = 1'b1; @(negedge clk_i); rx_rd_i = 1'b0;
  endtask
  task automatic tx_wr();
    @(negedge clk_i); tx_wr_i = 1'b1; @(negedge clk_i); tx_wr_i = 1'b0;
  endtask
  task automatic ack(input logic [2:0] i);
    @(negedge clk_i); ack_i = 1'b1; ack_idx_i = i; @(negedge clk_i); ack_i = 1'b0;
  endtask
  task automatic bz();
    @(negedge clk_i); baud_zero_i = 1'b1; @(negedge clk_i); baud_zero_i = 1'b0;
  endtask
  task automatic ticks(input int n, input logic lvl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); bit_tick_i = 1'b1; rxd_i = lvl;
      @(negedge clk_i); bit_tick_i = 1'b0;
    end
  endtask
  task automatic lvl(input logic rf, input logic pe, input logic fe, input logic oe, input logic te);
    @(negedge clk_i);
    rx_full_i = rf; par_err_i = pe; frm_err_i = fe; ovr_err_i = oe; tx_empty_i = te;
  endtask

  task automatic t_reset();
    check(1'b0, 3'd0, "R1 reset idle");
    lvl(1, 1, 0, 0, 1);
    bz();
    check(1'b0, 3'd0, "R1 control cleared at reset");
    lvl(0, 0, 0, 0, 0);
  endtask

  task automatic t_err();
    set_ctrl(ALL_EN);
    lvl(1, 1, 0, 0, 0);
    check(1'b1, 3'd0, "R3 parity error request");
    rx_rd();
    check(1'b1, 3'd0, "R3 data read alone keeps error");
    stat_rd();
    check(1'b1, 3'd0, "R3 status read alone keeps error");
    rx_rd();
    check(1'b0, 3'd0, "R3 status then data read clears");
    lvl(0, 0, 0, 0, 0);
    lvl(1, 0, 0, 1, 0);
    check(1'b1, 3'd0, "R3 overrun error request");
    stat_rd(); rx_rd();
    check(1'b0, 3'd0, "R3 overrun cleared");
    lvl(0, 0, 0, 0, 0);
    set_ctrl(ALL_EN & ~24'h010000);
    lvl(1, 0, 1, 0, 0);
    check(1'b1, 3'd1, "R4 framing error with error source off gives receive");
    lvl(0, 0, 0, 0, 0);
  endtask

  task automatic t_rx();
    set_ctrl(ALL_EN);
    lvl(1, 0, 0, 0, 1);
    check(1'b1, 3'd1, "R4 receive over transmit");
    rx_rd();
    check(1'b1, 3'd2, "R4 read clears receive");
    lvl(0, 0, 0, 0, 1);
    lvl(1, 0, 0, 0, 1);
    check(1'b1, 3'd1, "R4 new character re-arms");
    rx_rd();
    lvl(0, 0, 0, 0, 0);
  endtask

  task automatic t_tx();
    set_ctrl(ALL_EN);
    lvl(0, 0, 0, 0, 1);
    check(1'b1, 3'd2, "R5 transmit empty request");
    tx_wr();
    check(1'b0, 3'd0, "R5 write clears transmit");
    lvl(0, 0, 0, 0, 0);
    lvl(0, 0, 0, 0, 1);
    check(1'b1, 3'd2, "R5 re-arm after empty edge");
    set_ctrl(ALL_EN & ~24'h001000);
    check(1'b0, 3'd0, "R8 transmit disabled");
    lvl(0, 0, 0, 0, 0);
  endtask

  task automatic t_idle();
    set_ctrl(ALL_EN);
    frame11_i = 1'b0;
    ticks(1, 0);
    ticks(9, 1);
    check(1'b0, 3'd0, "R6 nine high ticks short of 10");
    ticks(1, 1);
    check(1'b1, 3'd3, "R6 tenth high tick latches idle");
    ack(3'd4);
    check(1'b1, 3'd3, "R9 foreign ack keeps idle");
    ack(3'd3);
    check(1'b0, 3'd0, "R9 own ack clears idle");
    ticks(5, 1);
    check(1'b0, 3'd0, "R6 once per high stretch");
    ticks(1, 0);
    frame11_i = 1'b1;
    ticks(10, 1);
    check(1'b0, 3'd0, "R6 ten ticks short in 11-bit mode");
    ticks(1, 1);
    check(1'b1, 3'd3, "R6 eleventh tick latches in 11-bit mode");
    ack(3'd3);
    ticks(1, 0);
    frame11_i = 1'b0;
  endtask

  task automatic t_tmr();
    set_ctrl(ALL_EN & ~24'h002000);
    bz();
    check(1'b0, 3'd0, "R8 timer disabled");
    set_ctrl(ALL_EN);
    check(1'b0, 3'd0, "R8 disabled event not latched");
    bz();
    check(1'b1, 3'd4, "R7 timer latched");
    ack(3'd3);
    check(1'b1, 3'd4, "R9 idle ack keeps timer");
    ack(3'd4);
    check(1'b0, 3'd0, "R7 timer ack clears");
  endtask

  task automatic t_stack();
    set_ctrl(ALL_EN);
    bz();
    ticks(1, 0);
    ticks(10, 1);
    lvl(1, 1, 0, 0, 1);
    check(1'b1, 3'd0, "R2 all pending shows error");
    stat_rd(); rx_rd();
    check(1'b1, 3'd2, "R2 transmit next");
    tx_wr();
    check(1'b1, 3'd3, "R2 idle next");
    ack(3'd3);
    check(1'b1, 3'd4, "R2 timer last");
    ack(3'd4);
    check(1'b0, 3'd0, "R10 nothing pending");
    lvl(0, 0, 0, 0, 0);
    ticks(1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_err();
    t_rx();
    t_tx();
    t_idle();
    t_tmr();
    t_stack();
    repeat (2) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule